// File: doc/BRIEF.md
# Compact Branch Condition Resolver

This unit resolves compact branches, which have no delay slot. Each strobe delivers a 32-bit instruction word, the address of that instruction and the values of the two source registers. The unit decides whether the branch is taken, computes where it goes, and states whether the return address must be written to a link register. The register file, the fetch unit and link write-back sit outside the block. The block only presents the link request and the value to write.

Several major opcodes are shared by more than one branch kind. The kind is chosen by how the two 5-bit register-number fields relate to each other: one may be zero, the two may be equal, or one may be ordered above the other. One opcode pair does not compare the two registers at all. It tests whether their 32-bit signed sum overflows. Results are registered and appear one cycle after the strobe, together with a one-cycle valid pulse.

Fields: opcode is bits [31:26], the first register field (rs) is bits [25:21] and the second (rt) is bits [20:16]. "a" is the value of rs and "b" is the value of rt. Unless a requirement says otherwise, the target is pc + 4 + (sign-extended bits [15:0] shifted left by 2).

Top module: `cbr_resolver`

## Requirements
- R1: While reset is held and after it is released, valid_o, taken_o and link_o are 0 until a strobe is accepted.
- R2: A valid_i strobe in cycle n produces results and a single-cycle valid_o in cycle n+1. Without a strobe, valid_o is 0 and the other outputs hold their values.
- R3: For the 16-bit PC-relative forms, target_o = pc + 4 + (sign-extended bits [15:0] << 2). This target is reported whether or not the branch is taken.
- R4: Opcode 010110 selects by field relation. If rs=0 and rt≠0, it is taken when b ≤ 0 (signed). If rs≠0 and rs=rt, it is taken when b ≥ 0. Otherwise it is taken when a ≥ b (signed).
- R5: Opcode 010111 uses the same field relations as R4 and is taken when b > 0, when b < 0, and when a < b (signed), respectively.
- R6: Opcodes 000110 and 000111 follow R4 and R5, but the last case compares unsigned (a ≥ b and a < b) and link_o is 1. When the rt field is 0, the branch is not taken and link_o is 0.
- R7: Opcode 001000 selects by field relation. If field rs ≥ field rt, it is taken when a + b overflows as a 32-bit signed sum. Otherwise, if rs=0, it is taken when b = 0 and link_o is 1. Otherwise it is taken when a = b.
- R8: Opcode 011000 complements R7: it is taken on no overflow, is taken with link when b ≠ 0, and is taken when a ≠ b.
- R9: Opcode 110110 with rs≠0 is taken when a = 0. Opcode 111110 with rs≠0 is taken when a ≠ 0. Both use target pc + 4 + (sign-extended bits [20:0] << 2). Opcode 111110 with rs=0 is not taken and does not link.
- R10: Opcode 110110 with rs=0 is always taken, with target b + (sign-extended bits [15:0] << 2).
- R11: Opcodes 110010 and 111010 are always taken, with target pc + 4 + (sign-extended bits [25:0] << 2). Only 111010 sets link_o.
- R12: link_val_o = pc + 4, and link_o is set for every linking form whether or not it is taken. Any other opcode gives taken_o = 0 and link_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input strobe |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| rs_val_i | input | XLEN | Value of register named by bits [25:21] |
| rt_val_i | input | XLEN | Value of register named by bits [20:16] |
| valid_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| target_o | output | XLEN | Branch target address |
| link_o | output | 1 | Link write request |
| link_val_o | output | XLEN | Value to write to the link register |

## Verification
The hardest case to reach is when the register fields alone decide the branch kind. The same opcode and the same operand values can lead to opposite outcomes, depending only on whether rs is zero, equals rt, or is above rt. The stimulus therefore holds the operand values fixed and varies only the field numbers. It does this for the overflow-or-link-or-equal opcode pair and for the signed and unsigned compare pairs. It also chooses operand values such as 0xFFFFFFFE against 1, on which the signed and unsigned orders disagree. The rt-field-zero case of the linking opcodes and the rs-field-zero case of 111110 are driven on purpose, to show that nothing is taken or linked.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam logic [5:0] OP_BC      = 6'b110010;
  localparam logic [5:0] OP_BALC    = 6'b111010;
  localparam logic [5:0] OP_ZEQ_JR  = 6'b110110;
  localparam logic [5:0] OP_ZNE     = 6'b111110;
  localparam logic [5:0] OP_LE_GE   = 6'b010110;
  localparam logic [5:0] OP_GT_LT   = 6'b010111;
  localparam logic [5:0] OP_LE_GE_L = 6'b000110;
  localparam logic [5:0] OP_GT_LT_L = 6'b000111;
  localparam logic [5:0] OP_OV_EQ   = 6'b001000;
  localparam logic [5:0] OP_NV_NE   = 6'b011000;

  typedef enum logic [4:0] {
    C_NEVER, C_ALWAYS,
    C_B_LEZ, C_B_GEZ, C_B_GTZ, C_B_LTZ,
    C_GE, C_LT, C_GEU, C_LTU, C_EQ, C_NE,
    C_A_EQZ, C_A_NEZ, C_B_EQZ, C_B_NEZ,
    C_OVF, C_NOVF
  } cond_e;

  typedef enum logic [1:0] {T_OFF16, T_OFF21, T_OFF26, T_REG} tgt_e;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [15:0] instr_hi_i,
  output cond_e       cond_o,
  output tgt_e        tgt_o,
  output logic        link_o
);
  logic [5:0] op;
  logic [4:0] rs_f, rt_f;
  logic       rs_z, rt_z, same;

  assign op   = instr_hi_i[15:10];
  assign rs_f = instr_hi_i[9:5];
  assign rt_f = instr_hi_i[4:0];
  assign rs_z = (rs_f == '0);
  assign rt_z = (rt_f == '0);
  assign same = (rs_f == rt_f);

  always_comb begin
    cond_o = C_NEVER;
    tgt_o  = T_OFF16;
    link_o = 1'b0;
    unique case (op)
      OP_BC:   begin cond_o = C_ALWAYS; tgt_o = T_OFF26; end
      OP_BALC: begin cond_o = C_ALWAYS; tgt_o = T_OFF26; link_o = 1'b1; end
      OP_ZEQ_JR: begin
        if (!rs_z) begin cond_o = C_A_EQZ; tgt_o = T_OFF21; end
        else       begin cond_o = C_ALWAYS; tgt_o = T_REG; end
      end
      OP_ZNE: begin
        if (!rs_z) begin cond_o = C_A_NEZ; tgt_o = T_OFF21; end
      end
      OP_LE_GE: begin
        if (rs_z && !rt_z)       cond_o = C_B_LEZ;
        else if (!rs_z && same)  cond_o = C_B_GEZ;
        else                     cond_o = C_GE;
      end
      OP_GT_LT: begin
        if (rs_z && !rt_z)       cond_o = C_B_GTZ;
        else if (!rs_z && same)  cond_o = C_B_LTZ;
        else                     cond_o = C_LT;
      end
      OP_LE_GE_L: begin
        if (!rt_z) begin
          link_o = 1'b1;
          if (rs_z)      cond_o = C_B_LEZ;
          else if (same) cond_o = C_B_GEZ;
          else           cond_o = C_GEU;
        end
      end
      OP_GT_LT_L: begin
        if (!rt_z) begin
          link_o = 1'b1;
          if (rs_z)      cond_o = C_B_GTZ;
          else if (same) cond_o = C_B_LTZ;
          else           cond_o = C_LTU;
        end
      end
      OP_OV_EQ: begin
        if (rs_f >= rt_f) cond_o = C_OVF;
        else if (rs_z)    begin cond_o = C_B_EQZ; link_o = 1'b1; end
        else              cond_o = C_EQ;
      end
      OP_NV_NE: begin
        if (rs_f >= rt_f) cond_o = C_NOVF;
        else if (rs_z)    begin cond_o = C_B_NEZ; link_o = 1'b1; end
        else              cond_o = C_NE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cond_e           cond_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            taken_o
);
  logic [XLEN-1:0] sum;
  logic a_z, b_z, b_neg, eq, slt, ult, ovf;

  assign sum   = a_i + b_i;
  // signed overflow: like-signed operands, result sign differs
  assign ovf   = (a_i[XLEN-1] == b_i[XLEN-1]) && (sum[XLEN-1] != a_i[XLEN-1]);
  assign a_z   = (a_i == '0);
  assign b_z   = (b_i == '0);
  assign b_neg = b_i[XLEN-1];
  assign eq    = (a_i == b_i);
  assign slt   = ($signed(a_i) < $signed(b_i));
  assign ult   = (a_i < b_i);

  always_comb begin
    unique case (cond_i)
      C_ALWAYS: taken_o = 1'b1;
      C_B_LEZ:  taken_o = b_neg || b_z;
      C_B_GEZ:  taken_o = !b_neg;
      C_B_GTZ:  taken_o = !b_neg && !b_z;
      C_B_LTZ:  taken_o = b_neg;
      C_GE:     taken_o = !slt;
      C_LT:     taken_o = slt;
      C_GEU:    taken_o = !ult;
      C_LTU:    taken_o = ult;
      C_EQ:     taken_o = eq;
      C_NE:     taken_o = !eq;
      C_A_EQZ:  taken_o = a_z;
      C_A_NEZ:  taken_o = !a_z;
      C_B_EQZ:  taken_o = b_z;
      C_B_NEZ:  taken_o = !b_z;
      C_OVF:    taken_o = ovf;
      C_NOVF:   taken_o = !ovf;
      default:  taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  tgt_e            tgt_i,
  input  logic [25:0]     off_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] base_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] next_pc_o
);
  localparam int W16 = 16;
  localparam int W21 = 21;
  localparam int W26 = 26;

  logic [XLEN-1:0] off16, off21, off26;

  assign off16 = {{(XLEN-W16-2){off_i[W16-1]}}, off_i[W16-1:0], 2'b00};
  assign off21 = {{(XLEN-W21-2){off_i[W21-1]}}, off_i[W21-1:0], 2'b00};
  assign off26 = {{(XLEN-W26-2){off_i[W26-1]}}, off_i[W26-1:0], 2'b00};
  assign next_pc_o = pc_i + XLEN'(4);

  always_comb begin
    unique case (tgt_i)
      T_OFF21: target_o = next_pc_o + off21;
      T_OFF26: target_o = next_pc_o + off26;
      T_REG:   target_o = base_i + off16;
      default: target_o = next_pc_o + off16;
    endcase
  end
endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic            valid_o,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o,
  output logic            link_o,
  output logic [XLEN-1:0] link_val_o
);
  cond_e           cond;
  tgt_e            tgt;
  logic            link_d, taken_d;
  logic [XLEN-1:0] target_d, next_pc;

  cbr_decode u_decode (
    .instr_hi_i (instr_i[31:16]),
    .cond_o     (cond),
    .tgt_o      (tgt),
    .link_o     (link_d)
  );

  cbr_cond #(.XLEN(XLEN)) u_cond (
    .cond_i  (cond),
    .a_i     (rs_val_i),
    .b_i     (rt_val_i),
    .taken_o (taken_d)
  );

  cbr_target #(.XLEN(XLEN)) u_target (
    .tgt_i     (tgt),
    .off_i     (instr_i[25:0]),
    .pc_i      (pc_i),
    .base_i    (rt_val_i),
    .target_o  (target_d),
    .next_pc_o (next_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      link_o     <= 1'b0;
      target_o   <= '0;
      link_val_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o    <= taken_d;
        link_o     <= link_d;
        target_o   <= target_d;
        link_val_o <= next_pc;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(taken_o) && $stable(target_o));
  p_link_val_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && link_o |-> link_val_o == $past(pc_i) + XLEN'(4));
  p_uncond_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[31:26] == OP_BC || instr_i[31:26] == OP_BALC) |=> taken_o);
  p_rt_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[31:26] == OP_LE_GE_L || instr_i[31:26] == OP_GT_LT_L)
      && instr_i[20:16] == 5'd0 |=> !taken_o && !link_o);
  p_pair_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[31:26] == OP_LE_GE_L || instr_i[31:26] == OP_GT_LT_L)
      && instr_i[20:16] != 5'd0 |=> link_o);
endmodule

// File: tb/cbr_resolver_tb.sv
module cbr_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0, pc_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic        valid_o, taken_o, link_o;
  logic [31:0] target_o, link_val_o;
  int total = 0, bad = 0;

  localparam logic [31:0] PC = 32'h0000_1000;

  always #10 clk = ~clk;

  cbr_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .valid_o(valid_o), .taken_o(taken_o), .target_o(target_o),
    .link_o(link_o), .link_val_o(link_val_o)
  );

  function automatic logic [31:0] f16(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] off);
    return {op, rs, rt, off};
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    valid_i = 1'b1; instr_i = ins; pc_i = PC; rs_val_i = a; rt_val_i = b;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic et, input logic el,
                     input logic ct, input logic [31:0] etgt);
    total++;
    if (valid_o !== 1'b1 || taken_o !== et || link_o !== el ||
        (ct && target_o !== etgt) || (el && link_val_o !== PC + 32'd4)) begin
      bad++;
      $display("FAIL %s: v=%b t=%b l=%b tgt=%h lv=%h exp t=%b l=%b tgt=%h lv=%h",
               req, valid_o, taken_o, link_o, target_o, link_val_o,
               et, el, etgt, PC + 32'd4);
    end
  endtask

  task automatic t_reset();
    total++;
    if (valid_o !== 1'b0 || taken_o !== 1'b0 || link_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: v=%b t=%b l=%b exp 0 0 0", valid_o, taken_o, link_o);
    end
  endtask

  task automatic t_hold_r2();
    issue(f16(6'b110010, 5'd0, 5'd0, 16'h0), 0, 0);
    chk("R2 strobe", 1'b1, 1'b0, 1'b0, 0);
    @(negedge clk); @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || taken_o !== 1'b1) begin
      bad++;
      $display("FAIL R2 hold: v=%b t=%b exp v=0 t=1", valid_o, taken_o);
    end
  endtask

  task automatic t_r3_r4();
    issue(f16(6'b010110, 5'd0, 5'd5, 16'h0010), 0, 0);
    chk("R3 R4 lez b=0", 1, 0, 1, 32'h1044);
    issue(f16(6'b010110, 5'd0, 5'd5, 16'hFFFF), 0, 1);
    chk("R3 R4 lez b=1 not taken target", 0, 0, 1, 32'h1000);
    issue(f16(6'b010110, 5'd5, 5'd5, 16'h0), 0, 32'hFFFF_FFFF);
    chk("R4 gez b=-1", 0, 0, 0, 0);
    issue(f16(6'b010110, 5'd5, 5'd5, 16'h0), 0, 0);
    chk("R4 gez b=0", 1, 0, 0, 0);
    issue(f16(6'b010110, 5'd3, 5'd4, 16'h0), 32'hFFFF_FFFE, 1);
    chk("R4 ge -2>=1", 0, 0, 0, 0);
    issue(f16(6'b010110, 5'd3, 5'd4, 16'h0), 7, 7);
    chk("R4 ge 7>=7", 1, 0, 0, 0);
  endtask

  task automatic t_r5();
    issue(f16(6'b010111, 5'd0, 5'd5, 16'h0), 0, 1);
    chk("R5 gtz b=1", 1, 0, 0, 0);
    issue(f16(6'b010111, 5'd0, 5'd5, 16'h0), 0, 0);
    chk("R5 gtz b=0", 0, 0, 0, 0);
    issue(f16(6'b010111, 5'd6, 5'd6, 16'h0), 0, 32'hFFFF_FFFF);
    chk("R5 ltz b=-1", 1, 0, 0, 0);
    issue(f16(6'b010111, 5'd3, 5'd4, 16'h0), 32'hFFFF_FFFE, 1);
    chk("R5 lt -2<1", 1, 0, 0, 0);
  endtask

  task automatic t_r6();
    issue(f16(6'b000110, 5'd3, 5'd4, 16'h0), 32'hFFFF_FFFE, 1);
    chk("R6 geu", 1, 1, 0, 0);
    issue(f16(6'b000111, 5'd3, 5'd4, 16'h0), 32'hFFFF_FFFE, 1);
    chk("R6 ltu", 0, 1, 0, 0);
    issue(f16(6'b000110, 5'd0, 5'd4, 16'h0), 0, 5);
    chk("R6 R12 lez link untaken", 0, 1, 0, 0);
    issue(f16(6'b000111, 5'd0, 5'd4, 16'h0), 0, 5);
    chk("R6 gtz link", 1, 1, 0, 0);
    issue(f16(6'b000110, 5'd3, 5'd0, 16'h0), 5, 0);
    chk("R6 rt field zero", 0, 0, 0, 0);
  endtask

  task automatic t_r7();
    issue(f16(6'b001000, 5'd5, 5'd3, 16'h0), 32'h7FFF_FFFF, 1);
    chk("R7 ovf", 1, 0, 0, 0);
    issue(f16(6'b001000, 5'd5, 5'd3, 16'h0), 1, 1);
    chk("R7 no ovf", 0, 0, 0, 0);
    issue(f16(6'b001000, 5'd0, 5'd3, 16'h0), 9, 0);
    chk("R7 eqz link", 1, 1, 0, 0);
    issue(f16(6'b001000, 5'd2, 5'd3, 16'h0), 1, 1);
    chk("R7 eq", 1, 0, 0, 0);
    issue(f16(6'b001000, 5'd2, 5'd3, 16'h0), 1, 2);
    chk("R7 ne values", 0, 0, 0, 0);
  endtask

  task automatic t_r8();
    issue(f16(6'b011000, 5'd5, 5'd3, 16'h0), 32'h7FFF_FFFF, 1);
    chk("R8 ovf", 0, 0, 0, 0);
    issue(f16(6'b011000, 5'd5, 5'd3, 16'h0), 1, 1);
    chk("R8 no ovf", 1, 0, 0, 0);
    issue(f16(6'b011000, 5'd0, 5'd3, 16'h0), 0, 7);
    chk("R8 nez link", 1, 1, 0, 0);
    issue(f16(6'b011000, 5'd2, 5'd3, 16'h0), 1, 2);
    chk("R8 ne", 1, 0, 0, 0);
  endtask

  task automatic t_r9();
    issue({6'b110110, 5'd2, 21'h1F_FFFF}, 0, 0);
    chk("R9 eqz off21", 1, 0, 1, 32'h1000);
    issue({6'b111110, 5'd2, 21'h00_0100}, 9, 0);
    chk("R9 nez off21", 1, 0, 1, 32'h1404);
    issue({6'b111110, 5'd2, 21'h00_0100}, 0, 0);
    chk("R9 nez a=0", 0, 0, 0, 0);
    issue(f16(6'b111110, 5'd0, 5'd4, 16'h0), 1, 1);
    chk("R9 rs field zero", 0, 0, 0, 0);
  endtask

  task automatic t_r10();
    issue(f16(6'b110110, 5'd0, 5'd7, 16'h0008), 32'h5555, 32'h2000);
    chk("R10 reg jump", 1, 0, 1, 32'h2020);
  endtask

  task automatic t_r11();
    issue({6'b110010, 26'h3FF_FFFE}, 0, 0);
    chk("R11 bc", 1, 0, 1, 32'h0FFC);
    issue({6'b111010, 26'h000_0040}, 0, 0);
    chk("R11 R12 balc", 1, 1, 1, 32'h1104);
  endtask

  task automatic t_r12();
    issue(f16(6'b000000, 5'd1, 5'd2, 16'h0), 0, 0);
    chk("R12 other opcode", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_r2();
    t_r3_r4();
    t_r5();
    t_r6();
    t_r7();
    t_r8();
    t_r9();
    t_r10();
    t_r11();
    t_r12();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule